// File: doc/BRIEF.md
# Multichannel ADC Acquisition Sequencer

This block is the host-side serial master for a multichannel successive-approximation converter with a byte-oriented serial port (active-low chip select, serial clock, command input and result output). A single `start` pulse latches which channels are enabled and how each one is set up: its input range code and whether it is single-ended or differential. The sequencer then sends one configuration frame to each enabled channel in ascending order. After that pass it cycles through the enabled channels forever, running one conversion frame per channel. Each 14-bit result is delivered with its channel number on a valid/ready port.

The serial clock comes from the system clock through a divider. Each SCLK phase lasts `SCLK_HALF` system cycles. Chip select is held low for a programmable number of cycles before the first SCLK rise of each frame. Between frames it is held high for at least a programmable number of cycles. A frame does not begin while an earlier result is still waiting to be accepted.

The controller has four states. `ST_IDLE` waits for `start` with a non-empty mask. `ST_SETUP` holds chip select low for the setup interval. `ST_SHIFT` runs SCLK and moves the command and result bits. `ST_GAP` holds chip select high. The transitions are:
- idle→setup on an accepted start;
- setup→shift when the setup count expires;
- shift→gap on the falling SCLK edge that ends the frame;
- gap→setup when the idle count has expired and no result is pending, or the pending result is accepted in that cycle.

Top module: `adc_seq_master`

## Requirements
- R1: After reset `adc_cs_n` is 1, `adc_sclk` is 0, `adc_din` is 0 and `res_valid` is 0, and they stay so until an accepted start.
- R2: A `start` pulse latches `ch_enable`, `ch_diff` and `ch_range`. Later changes on those inputs have no effect. One configuration frame is sent to each enabled channel in ascending channel order before any conversion frame. A `start` with an all-zero mask produces no frame.
- R3: A configuration frame has exactly 8 SCLK cycles. Its command byte, MSB first, is 1, then channel bits [2:0], then the differential bit (`ch_diff[c]`), then range bits [2:0] (`ch_range[3c+2:3c]`). DIN is stable at every SCLK rising edge.
- R4: A conversion frame has exactly 24 SCLK cycles. Its command byte, MSB first, is 1, then channel bits [2:0], then 0000.
- R5: `res_data` is made of the DOUT values sampled at the 9th through 22nd SCLK rising edges of a conversion frame, first sample in bit 13. Samples at edges 23 and 24 have no effect on the result.
- R6: Conversion frames visit the enabled channels in ascending order, wrapping from the highest enabled channel to the lowest, and skip disabled channels. `res_chan` carries the channel of each result.
- R7: In every frame, chip select is low for at least `CS_SETUP_CYC` system cycles before the first SCLK rise. SCLK is low whenever chip select is high.
- R8: Between consecutive frames, chip select stays high for at least `CS_IDLE_CYC` system cycles.
- R9: Within a frame, every SCLK high phase lasts `SCLK_HALF` cycles, and successive rising edges are `2*SCLK_HALF` cycles apart.
- R10: While `res_valid` is 1 and `res_ready` is 0, `res_valid`, `res_data` and `res_chan` hold. Chip select never goes low while a result is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Latches the channel setup and begins the sequence |
| ch_enable | input | NCH | Per-channel enable mask |
| ch_diff | input | NCH | Per-channel differential select |
| ch_range | input | 3*NCH | Per-channel 3-bit range code, channel c at [3c+2:3c] |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sclk | output | 1 | Converter serial clock |
| adc_din | output | 1 | Command bits to the converter |
| adc_dout | input | 1 | Result bits from the converter |
| res_valid | output | 1 | Result available |
| res_data | output | RES_W | Conversion result |
| res_chan | output | 3 | Channel of the result |
| res_ready | input | 1 | Consumer accepts the result |

## Verification
The two functions that can land in the same cycle are the end of the chip-select idle interval and the acceptance of a pending result. The gap→setup decision depends on both. The bench provokes this with a pseudo-random ready pattern that sometimes releases a stalled result exactly as the idle count expires, and sometimes long before or after. It then judges the outcome at the converter pins: chip select must never fall while a result is pending, the idle interval must never fall short of its minimum, and each held result must stay unchanged until the cycle in which it is taken.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int CH_W   = 3;
    localparam int CMD_W  = 8;
    localparam int TAIL_W = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_SHIFT,
        ST_GAP
    } seq_state_t;

    // setup byte: marker, channel, diff flag, range code
    function automatic logic [CMD_W-1:0] cfg_cmd(input logic [CH_W-1:0] ch,
                                                 input logic diff,
                                                 input logic [2:0] rng);
        return {1'b1, ch, diff, rng};
    endfunction

    // conversion byte: marker, channel, four zero bits
    function automatic logic [CMD_W-1:0] conv_cmd(input logic [CH_W-1:0] ch);
        return {1'b1, ch, 4'b0000};
    endfunction

endpackage

// File: rtl/adc_seq_sclk.sv
module adc_seq_sclk #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk,
    output logic rise,
    output logic fall
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt  <= '0;
            sclk <= 1'b0;
        end else if (cnt == LAST) begin
            cnt  <= '0;
            sclk <= ~sclk;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign rise = run && (cnt == LAST) && !sclk;
    assign fall = run && (cnt == LAST) && sclk;

    AST_SCLK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !sclk); // R7

endmodule

// File: rtl/adc_seq_pick.sv
module adc_seq_pick #(
    parameter int NCH = 8
) (
    input  logic [NCH-1:0] mask,
    input  logic [2:0]     cur,
    output logic [2:0]     nxt,
    output logic           any
);
    // first enabled channel strictly after cur, wrapping round to cur itself
    always_comb begin
        int idx;
        nxt = cur;
        any = 1'b0;
        for (int k = NCH; k >= 1; k--) begin
            idx = (int'(cur) + k) % NCH;
            if (mask[idx]) begin
                nxt = idx[2:0];
                any = 1'b1;
            end
        end
    end

endmodule

// File: rtl/adc_seq_master.sv
module adc_seq_master
    import adc_seq_pkg::*;
#(
    parameter int NCH          = 8,
    parameter int SCLK_HALF    = 2,
    parameter int CS_SETUP_CYC = 10,
    parameter int CS_IDLE_CYC  = 10,
    parameter int RES_W        = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [NCH-1:0]     ch_enable,
    input  logic [NCH-1:0]     ch_diff,
    input  logic [3*NCH-1:0]   ch_range,
    output logic               adc_cs_n,
    output logic               adc_sclk,
    output logic               adc_din,
    input  logic               adc_dout,
    output logic               res_valid,
    output logic [RES_W-1:0]   res_data,
    output logic [2:0]         res_chan,
    input  logic               res_ready
);
    localparam int CONV_BITS = CMD_W + RES_W + TAIL_W;
    localparam int BIT_W     = $clog2(CONV_BITS + 1);
    localparam int TMR_MAX   = (CS_SETUP_CYC > CS_IDLE_CYC) ? CS_SETUP_CYC : CS_IDLE_CYC;
    localparam int TMR_W     = $clog2(TMR_MAX + 1);

    localparam logic [BIT_W-1:0] CFG_LEN   = BIT_W'(CMD_W);
    localparam logic [BIT_W-1:0] CONV_LEN  = BIT_W'(CONV_BITS);
    localparam logic [BIT_W-1:0] RES_FIRST = BIT_W'(CMD_W);
    localparam logic [BIT_W-1:0] RES_END   = BIT_W'(CMD_W + RES_W);
    localparam logic [TMR_W-1:0] SETUP_LST = TMR_W'(CS_SETUP_CYC - 1);
    localparam logic [TMR_W-1:0] IDLE_LST  = TMR_W'(CS_IDLE_CYC - 1);
    localparam logic [TMR_W-1:0] TMR_SAT   = TMR_W'(TMR_MAX);

    seq_state_t            state_q, state_d;
    logic [NCH-1:0]        mask_q, diff_q;
    logic [3*NCH-1:0]      rng_q;
    logic [2:0]            cur_ch;
    logic                  conv_q;
    logic [TMR_W-1:0]      tmr;
    logic [BIT_W-1:0]      bitcnt;
    logic [CMD_W-1:0]      tx;
    logic [RES_W-1:0]      rx;
    logic                  res_valid_q;
    logic [RES_W-1:0]      res_data_q;
    logic [2:0]            res_chan_q;

    logic                  sck_run, sck_rise, sck_fall, sck_lvl;
    logic [2:0]            first_ch, next_ch;
    logic                  first_any, next_any;
    logic                  go, setup_done, gap_done, frame_end, wrap_next;
    logic [BIT_W-1:0]      flen;

    adc_seq_sclk #(.HALF(SCLK_HALF)) u_sclk (
        .clk(clk), .rst_n(rst_n), .run(sck_run),
        .sclk(sck_lvl), .rise(sck_rise), .fall(sck_fall)
    );

    adc_seq_pick #(.NCH(NCH)) u_first (
        .mask(ch_enable), .cur(3'(NCH - 1)), .nxt(first_ch), .any(first_any)
    );

    adc_seq_pick #(.NCH(NCH)) u_next (
        .mask(mask_q), .cur(cur_ch), .nxt(next_ch), .any(next_any)
    );

    assign go         = start && first_any;
    assign setup_done = (tmr == SETUP_LST);
    assign gap_done   = (tmr >= IDLE_LST);
    assign flen       = conv_q ? CONV_LEN : CFG_LEN;
    assign frame_end  = sck_fall && (bitcnt == flen);
    assign wrap_next  = (next_ch <= cur_ch);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (go)         state_d = ST_SETUP;
            ST_SETUP: if (setup_done) state_d = ST_SHIFT;
            ST_SHIFT: if (frame_end)  state_d = ST_GAP;
            ST_GAP:   if (gap_done && (!res_valid_q || res_ready)) state_d = ST_SETUP;
            default:                  state_d = ST_IDLE;
        endcase
    end

    // datapath: latched setup, timers, shifters, result holding
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q      <= '0;
            diff_q      <= '0;
            rng_q       <= '0;
            cur_ch      <= '0;
            conv_q      <= 1'b0;
            tmr         <= '0;
            bitcnt      <= '0;
            tx          <= '0;
            rx          <= '0;
            res_valid_q <= 1'b0;
            res_data_q  <= '0;
            res_chan_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (go) begin
                        mask_q <= ch_enable;
                        diff_q <= ch_diff;
                        rng_q  <= ch_range;
                        cur_ch <= first_ch;
                        conv_q <= 1'b0;
                        tmr    <= '0;
                    end
                end
                ST_SETUP: begin
                    tmr <= tmr + 1'b1;
                    if (setup_done) begin
                        tx     <= conv_q ? conv_cmd(cur_ch)
                                         : cfg_cmd(cur_ch, diff_q[cur_ch],
                                                   rng_q[3*int'(cur_ch) +: 3]);
                        bitcnt <= '0;
                        rx     <= '0;
                    end
                end
                ST_SHIFT: begin
                    if (sck_rise) begin
                        bitcnt <= bitcnt + 1'b1;
                        if (bitcnt >= RES_FIRST && bitcnt < RES_END)
                            rx <= {rx[RES_W-2:0], adc_dout};
                    end
                    if (sck_fall) tx <= {tx[CMD_W-2:0], 1'b0};
                    if (frame_end) begin
                        tmr    <= '0;
                        cur_ch <= next_ch;
                        if (!conv_q && wrap_next) conv_q <= 1'b1;
                    end
                end
                ST_GAP: begin
                    if (state_d == ST_SETUP) tmr <= '0;
                    else if (tmr != TMR_SAT) tmr <= tmr + 1'b1;
                end
                default: ;
            endcase

            if (res_valid_q && res_ready) res_valid_q <= 1'b0;
            if (state_q == ST_SHIFT && frame_end && conv_q) begin
                res_valid_q <= 1'b1;
                res_data_q  <= rx;
                res_chan_q  <= cur_ch;
            end
        end
    end

    // outputs
    always_comb begin
        sck_run   = (state_q == ST_SHIFT);
        adc_cs_n  = !((state_q == ST_SETUP) || (state_q == ST_SHIFT));
        adc_sclk  = sck_lvl;
        adc_din   = (state_q == ST_SHIFT) ? tx[CMD_W-1] : 1'b0;
        res_valid = res_valid_q;
        res_data  = res_data_q;
        res_chan  = res_chan_q;
    end

    AST_SCLK_CS_PARK: assert property (@(posedge clk) disable iff (!rst_n)
        adc_cs_n |-> !adc_sclk); // R7
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(res_chan))); // R10
    AST_NO_FRAME_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> adc_cs_n); // R10
    AST_FRAME_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && sck_rise) |-> (bitcnt < flen)); // R4
    AST_CHAN_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT) |-> (next_any && mask_q[cur_ch])); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (adc_cs_n && !res_valid)); // R1

endmodule

// File: tb/adc_seq_master_test.sv
`timescale 1ns/1ps
module adc_seq_master_test;

    localparam int NCH  = 8;
    localparam int HALF = 2;
    localparam int CSS  = 10;
    localparam int IDL  = 10;
    localparam int AW   = 512;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [NCH-1:0]    ch_enable = '0;
    logic [NCH-1:0]    ch_diff = '0;
    logic [3*NCH-1:0]  ch_range = '0;
    logic              adc_cs_n, adc_sclk, adc_din;
    logic              adc_dout = 1'b0;
    logic              res_valid;
    logic [13:0]       res_data;
    logic [2:0]        res_chan;
    logic              res_ready = 1'b1;

    adc_seq_master #(.NCH(NCH), .SCLK_HALF(HALF), .CS_SETUP_CYC(CSS),
                     .CS_IDLE_CYC(IDL), .RES_W(14)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .ch_enable(ch_enable),
        .ch_diff(ch_diff), .ch_range(ch_range), .adc_cs_n(adc_cs_n),
        .adc_sclk(adc_sclk), .adc_din(adc_din), .adc_dout(adc_dout),
        .res_valid(res_valid), .res_data(res_data), .res_chan(res_chan),
        .res_ready(res_ready)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- converter model ----------------
    int          sbits = 0;
    logic [7:0]  sh = '0;
    logic [13:0] sval = '0;
    int          nconv = 0;
    int          nf = 0;
    int          ne = 0;
    logic [7:0]  fr_byte [AW];
    int          fr_len  [AW];
    logic [13:0] exp_d   [AW];

    function automatic logic [13:0] model(input logic [2:0] ch, input int n);
        return 14'(int'(ch) * 2651 + n * 311 + 8193);
    endfunction

    always @(negedge adc_cs_n or posedge adc_sclk) begin
        if (!adc_sclk) begin
            sbits = 0;
            sh = '0;
        end else if (!adc_cs_n) begin
            if (sbits < 8) sh = {sh[6:0], adc_din};
            sbits++;
            if (sbits == 8) sval = model(sh[6:4], nconv);
        end
    end

    always @(negedge adc_sclk) begin
        if (!adc_cs_n) begin
            if (sbits >= 8 && sbits < 22) adc_dout = sval[21 - sbits];
            else if (sbits >= 22)         adc_dout = 1'b1;  // tail bits must be dropped
            else                          adc_dout = 1'b0;
        end
    end

    always @(posedge adc_cs_n) begin
        if (rst_n) begin
            fr_byte[nf % AW] = sh;
            fr_len[nf % AW]  = sbits;
            nf++;
            if (sbits == 24) begin
                exp_d[ne % AW] = sval;
                ne++;
                nconv++;
            end
        end
    end

    // ---------------- cycle monitor ----------------
    int          v_setup = 0, v_idle = 0, v_width = 0, v_hold = 0;
    int          nres = 0;
    logic [13:0] rs_d [AW];
    logic [2:0]  rs_c [AW];
    logic        sclk_p, cs_p, val_p, rdy_p;
    logic [13:0] d_p;
    logic [2:0]  c_p;
    int          hi_cnt, lo_cnt, cs_hi_cnt, last_rise, rises;
    bit          seen_frame;

    always @(negedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 190000);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
        if (!rst_n) begin
            sclk_p = 0; cs_p = 1; val_p = 0; rdy_p = 0; d_p = '0; c_p = '0;
            hi_cnt = 0; lo_cnt = 0; cs_hi_cnt = 0; last_rise = 0; rises = 0;
            seen_frame = 0;
        end else begin
            if (!adc_cs_n && cs_p) begin
                if (seen_frame && cs_hi_cnt < IDL) v_idle++;          // R8
                lo_cnt = 0;
                rises = 0;
            end
            if (adc_sclk) hi_cnt++;
            else begin
                if (sclk_p && hi_cnt != HALF) v_width++;             // R9
                hi_cnt = 0;
            end
            if (adc_sclk && !sclk_p) begin
                if (rises > 0 && cyc - last_rise != 2 * HALF) v_width++;  // R9
                if (rises == 0 && lo_cnt < CSS) v_setup++;                // R7
                rises++;
                last_rise = cyc;
            end
            if (!adc_cs_n) lo_cnt++;
            if (adc_cs_n) begin
                if (adc_sclk) v_setup++;                               // R7
                if (!cs_p) seen_frame = 1;
                cs_hi_cnt = cs_p ? cs_hi_cnt + 1 : 1;
            end
            if (val_p && !rdy_p && (!res_valid || res_data != d_p || res_chan != c_p))
                v_hold++;                                              // R10
            if (res_valid && !adc_cs_n) v_hold++;                      // R10
            if (res_valid && res_ready) begin
                rs_d[nres % AW] = res_data;
                rs_c[nres % AW] = res_chan;
                nres++;
            end
            sclk_p = adc_sclk; cs_p = adc_cs_n; val_p = res_valid;
            rdy_p = res_ready; d_p = res_data; c_p = res_chan;
        end
    end

    // ---------------- consumer ----------------
    bit          bp_mode = 0;
    logic [15:0] lfsr = 16'hACE1;
    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        res_ready = bp_mode ? (lfsr[1:0] == 2'b11) : 1'b1;
    end

    // ---------------- helpers ----------------
    function automatic int nxt_en(input logic [7:0] m, input int c);
        for (int k = 1; k <= 8; k++) begin
            if (m[(c + k) % 8]) return (c + k) % 8;
        end
        return c;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        start = 1'b0;
        bp_mode = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        repeat (20) @(negedge clk);
        chk(adc_cs_n == 1'b1,  "R1 cs_n idle",  int'(adc_cs_n), 1);
        chk(adc_sclk == 1'b0,  "R1 sclk idle",  int'(adc_sclk), 0);
        chk(adc_din == 1'b0,   "R1 din idle",   int'(adc_din), 0);
        chk(res_valid == 1'b0, "R1 valid idle", int'(res_valid), 0);
    endtask

    task automatic t_empty_mask();
        int f0;
        do_reset();
        f0 = nf;
        ch_enable = '0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (300) @(negedge clk);
        chk(nf == f0, "R2 empty mask sends no frame", nf - f0, 0);
        chk(adc_cs_n == 1'b1, "R2 empty mask cs_n", int'(adc_cs_n), 1);
    endtask

    task automatic t_run(input string name, input logic [7:0] mask, input logic [7:0] diff,
                         input logic [23:0] rng, input int want, input bit bp);
        int f0, e0, r0, vs, vi, vw, vh, en, ch, t0;
        do_reset();
        f0 = nf; e0 = ne; r0 = nres;
        vs = v_setup; vi = v_idle; vw = v_width; vh = v_hold;
        bp_mode = bp;
        ch_enable = mask; ch_diff = diff; ch_range = rng;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        ch_enable = ~mask; ch_diff = ~diff; ch_range = ~rng;   // must not matter after start
        t0 = cyc;
        while (nres - r0 < want && cyc - t0 < 40000) @(negedge clk);
        bp_mode = 0;
        chk(nres - r0 >= want, {name, " R6 results delivered"}, nres - r0, want);
        en = $countones(mask);
        ch = nxt_en(mask, 7);
        for (int i = 0; i < en; i++) begin
            chk(fr_len[(f0 + i) % AW] == 8, {name, " R3 config frame length"},
                fr_len[(f0 + i) % AW], 8);
            chk(fr_byte[(f0 + i) % AW] == {1'b1, 3'(ch), diff[ch], rng[3*ch +: 3]},
                {name, " R2 R3 config byte"}, int'(fr_byte[(f0 + i) % AW]),
                int'({1'b1, 3'(ch), diff[ch], rng[3*ch +: 3]}));
            ch = nxt_en(mask, ch);
        end
        ch = nxt_en(mask, 7);
        for (int j = 0; j < want; j++) begin
            chk(fr_len[(f0 + en + j) % AW] == 24, {name, " R4 conversion frame length"},
                fr_len[(f0 + en + j) % AW], 24);
            chk(fr_byte[(f0 + en + j) % AW] == {1'b1, 3'(ch), 4'b0000},
                {name, " R4 conversion byte"}, int'(fr_byte[(f0 + en + j) % AW]),
                int'({1'b1, 3'(ch), 4'b0000}));
            chk(rs_c[(r0 + j) % AW] == 3'(ch), {name, " R6 result channel"},
                int'(rs_c[(r0 + j) % AW]), ch);
            chk(rs_d[(r0 + j) % AW] == exp_d[(e0 + j) % AW], {name, " R5 result data"},
                int'(rs_d[(r0 + j) % AW]), int'(exp_d[(e0 + j) % AW]));
            ch = nxt_en(mask, ch);
        end
        chk(v_setup == vs, {name, " R7 cs setup / sclk parked"}, v_setup - vs, 0);
        chk(v_idle == vi,  {name, " R8 cs idle interval"}, v_idle - vi, 0);
        chk(v_width == vw, {name, " R9 sclk phase widths"}, v_width - vw, 0);
        chk(v_hold == vh,  {name, " R10 hold and no frame while pending"}, v_hold - vh, 0);
    endtask

    initial begin
        t_reset();
        t_empty_mask();
        t_run("sparse",    8'hA5, 8'h21, 24'h5A3C71, 12, 1'b0);
        t_run("single",    8'h80, 8'h80, 24'hE00000, 5,  1'b0);
        t_run("backpress", 8'h16, 8'h04, 24'h0F2B49, 10, 1'b1);
        t_run("all",       8'hFF, 8'h99, 24'hFAC688, 10, 1'b0);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule